// File: doc/BRIEF.md
# Biquinary Decade Counter

This block is a synchronous ten-state counter with a 4-bit state. The low three bits count from 0 to 4, and the top bit then changes, so the sequence splits into two halves of five states each. Because the halves are the same length, the top bit toggles once every five enabled clocks. It is therefore a divide-by-ten clock with an even duty cycle, and no extra decoding is needed to get it.

The state is held in plain D flip-flops fed by explicit next-state logic. Each of the six codes outside the sequence moves to a valid state on the next enabled edge, so the counter cannot lock up. A count enable freezes the state. A synchronous active-low reset returns the counter to the first state. A terminal-count flag marks the last state while counting is enabled, so a following stage can tell when the sequence wraps.

Top module: `biquinary_counter`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the state becomes 0000, whatever the value of `cnt_en`.
- R2: With `cnt_en` high, the state steps once per clock through 0000, 0001, 0010, 0011, 0100, 1000, 1001, 1010, 1011, 1100 and then repeats.
- R3: The half change goes from 0100 to 1000, and the wrap goes from 1100 to 0000. The top bit never rises from any other state.
- R4: With `cnt_en` low and `rst_n` high, the state keeps its value on every clock edge.
- R5: `div10_o` is bit 3 of the state. With the counter enabled, it stays low for five clocks and then high for five clocks.
- R6: The unused codes 0101, 0110 and 0111 have 1000 as their next state.
- R7: The unused codes 1101, 1110 and 1111 have 0000 as their next state.
- R8: `term_o` is high exactly when the state is 1100 and `cnt_en` is high.
- R9: After reset, the state never takes an unused code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every flip-flop updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable; the state holds while this is low |
| state_o | output | 4 | Present counter state |
| div10_o | output | 1 | Clock divided by ten, 50% duty cycle |
| term_o | output | 1 | Terminal-count flag |

## Verification
The bench compares every enabled step against the sequence position, which it computes as half times eight plus the count within the half. A design that counted in plain binary would leave 0100 for 0101, and the check would catch it. The bench measures the low and high runs of the divided output, so a half of the wrong length shows up as a 4/6 split. It sweeps all sixteen codes through the next-state logic, so an unused code that points at itself, or at another unused code, is reported. It also sets reset and enable high together, and drops the enable while the counter sits on the terminal state. Those cases expose a reset that loses to the enable, and a terminal flag that ignores the enable.

// File: rtl/bq_pkg.sv
// Package: shared widths and codes for the biquinary counter.
// Assumes a 4-bit state: one half-select bit over a 3-bit in-half count.
package bq_pkg;
    localparam int ST_W     = 4;
    localparam int LOW_W    = ST_W - 1;
    localparam int HALF_LEN = 5;
    localparam int LAST_LOW = HALF_LEN - 1;

    typedef logic [ST_W-1:0] bq_code_t;

    localparam bq_code_t FIRST_CODE = '0;
    localparam bq_code_t TERM_CODE  = {1'b1, LOW_W'(LAST_LOW)};

    // Returns true for the ten codes that belong to the sequence.
    function automatic logic is_valid(input bq_code_t c);
        return c[LOW_W-1:0] <= LOW_W'(LAST_LOW);
    endfunction
endpackage

// File: rtl/bq_next_state.sv
// Module: next-state logic for the biquinary sequence.
// Below the last in-half count it increments the low bits. At or above it,
// the half bit flips and the low bits clear. That rule also sends unused
// codes with the half bit low to 1000, and those with it high to 0000.
// Assumes: purely combinational; the caller registers the result.
module bq_next_state
    import bq_pkg::*;
(
    input  logic [ST_W-1:0] cur,
    output logic [ST_W-1:0] nxt
);
    logic [LOW_W-1:0] low;
    logic             half;
    logic             end_of_half;

    assign low         = cur[LOW_W-1:0];
    assign half        = cur[ST_W-1];
    assign end_of_half = (low >= LOW_W'(LAST_LOW));

    // Purpose: pick increment within the half or switch to the other half.
    always_comb begin
        if (end_of_half) begin
            nxt = {~half, {LOW_W{1'b0}}};
        end else begin
            nxt = {half, low + LOW_W'(1)};
        end
    end

    // Purpose: the next state is always a sequence member (R6, R7).
    always_comb begin
        if (!$isunknown(cur)) begin
            p_next_valid_r6_r7: assert (is_valid(nxt))
                else $error("next state %b from %b is unused", nxt, cur);
        end
    end
endmodule

// File: rtl/bq_state_reg.sv
// Module: enabled D flip-flop bank holding the counter state.
// Assumes: synchronous active-low reset with priority over the enable.
module bq_state_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // Purpose: one D flip-flop, cleared by reset, loaded when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else if (en) begin
                q[b] <= d[b];
            end
        end
    end

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q))
        else $error("state changed while disabled");
endmodule

// File: rtl/bq_status.sv
// Module: derives the divided clock and the terminal flag from the state.
// Assumes: the state comes straight from a register, so both outputs are
// glitch-free apart from the enable term on the terminal flag.
module bq_status
    import bq_pkg::*;
(
    input  logic [ST_W-1:0] state,
    input  logic            en,
    output logic            div_out,
    output logic            term_out
);
    // Purpose: the half bit is itself the divide-by-ten waveform.
    assign div_out  = state[ST_W-1];
    // Purpose: flag the last state while counting is enabled.
    assign term_out = en && (state == TERM_CODE);
endmodule

// File: rtl/biquinary_counter.sv
// Module: top of the biquinary decade counter.
// Wires next-state logic, the state register and the status decode.
// Assumes: a single clock; the reset is synchronous and active low.
module biquinary_counter
    import bq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_en,
    output logic [ST_W-1:0] state_o,
    output logic            div10_o,
    output logic            term_o
);
    logic [ST_W-1:0] cur_q;
    logic [ST_W-1:0] nxt_d;

    bq_next_state u_next (
        .cur (cur_q),
        .nxt (nxt_d)
    );

    bq_state_reg #(.W(ST_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .d     (nxt_d),
        .q     (cur_q)
    );

    bq_status u_status (
        .state    (cur_q),
        .en       (cnt_en),
        .div_out  (div10_o),
        .term_out (term_o)
    );

    assign state_o = cur_q;

    p_always_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_valid(state_o))
        else $error("unused state %b reached", state_o);

    p_half_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_o[ST_W-1]) |-> $past(state_o) == {1'b0, LOW_W'(LAST_LOW)})
        else $error("half bit rose from wrong state");

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == TERM_CODE && cnt_en) |=> state_o == FIRST_CODE)
        else $error("no wrap after terminal state");

    p_term_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> (!cnt_en || state_o == FIRST_CODE))
        else $error("terminal flag not followed by wrap");
endmodule

// File: tb/biquinary_counter_tb.sv
// Bench: exhaustive sequence, divider, hold, reset and next-state sweeps.
module biquinary_counter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [3:0] state_o;
    logic       div10_o;
    logic       term_o;
    logic [3:0] probe;
    logic [3:0] probe_nxt;

    int checks = 0;
    int fails  = 0;
    int idx    = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    biquinary_counter dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .state_o (state_o),
        .div10_o (div10_o),
        .term_o  (term_o)
    );

    bq_next_state nxt_i (.cur(probe), .nxt(probe_nxt));

    function automatic logic [3:0] code_of(input int k);
        return 4'((k / 5) * 8 + (k % 5));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lo_run;
        int hi_run;
        // R1: reset with enable high still gives 0000.
        cnt_en = 1'b1;
        tick(); tick();
        check("R1 reset state", state_o, 0);
        check("R5 div low in reset", div10_o, 0);
        rst_n = 1'b1;
        idx = 0;

        // R2/R3/R8: three full laps, every step compared.
        for (int s = 0; s < 30; s++) begin
            check("R8 term flag", term_o, (idx == 9) ? 1 : 0);
            tick();
            idx = (idx + 1) % 10;
            check("R2 sequence", state_o, code_of(idx));
            if (idx == 5) check("R3 half change", state_o, 8);
            if (idx == 0) check("R3 recycle", state_o, 0);
        end

        // R5: measure runs of the divided output over two periods.
        lo_run = 0; hi_run = 0;
        for (int s = 0; s < 20; s++) begin
            if (div10_o) hi_run++; else lo_run++;
            tick();
            idx = (idx + 1) % 10;
        end
        check("R5 low clocks", lo_run, 10);
        check("R5 high clocks", hi_run, 10);

        // R4/R8: park on the terminal state with the enable low.
        while (idx != 9) begin
            tick();
            idx = (idx + 1) % 10;
        end
        check("R8 term with enable", term_o, 1);
        cnt_en = 1'b0;
        #1;
        check("R8 term without enable", term_o, 0);
        for (int s = 0; s < 4; s++) begin
            tick();
            check("R4 hold", state_o, 12);
        end

        // R4: mixed enable pattern.
        for (int s = 0; s < 24; s++) begin
            cnt_en = (s % 3 != 0);
            tick();
            if (cnt_en) idx = (idx + 1) % 10;
            check("R4 gated count", state_o, code_of(idx));
        end

        // R1: reset beats enable mid-sequence.
        cnt_en = 1'b1;
        rst_n = 1'b0;
        tick();
        check("R1 reset over enable", state_o, 0);
        rst_n = 1'b1;

        // R6/R7: sweep all sixteen codes through the next-state logic.
        for (int c = 0; c < 16; c++) begin
            int exp;
            probe = 4'(c);
            #1;
            if (c % 8 < 4)       exp = c + 1;
            else if (c < 8)      exp = 8;
            else                 exp = 0;
            if (c % 8 > 4)
                check((c < 8) ? "R6 unused recovery" : "R7 unused recovery", probe_nxt, exp);
            else
                check("R2 next-state sweep", probe_nxt, exp);
        end

        finish_run();
    end
endmodule